// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

The unit watches a 16-bit free-running count, supplied from outside, and compares it with five 16-bit compare registers. Channel 0 is the master channel. When it fires, it can rewrite any of the five output pins at once: a 5-bit select register picks the pins, and a 5-bit level register gives the value each selected pin takes. Channels 1 to 4 each own one pin. Each has a 2-bit action that leaves the pin alone, inverts it, drives it low or drives it high.

The count may hold one value for many clock cycles behind a prescaler. A compare therefore fires only in the first cycle of an equality. Its effect appears on the next clock edge. Every firing sets the channel's sticky flag. A flag raises the interrupt line when the channel's enable bit is set. Software can also force a compare on any channel through a write-only register. Software writes the compare registers one byte at a time. Writing a high byte blocks that channel's compare for one cycle, so the low byte can follow without a spurious match.

Top module: `oc_unit`

## Requirements
- R1: The compare register of channel c has its high byte at write address 2c and its low byte at 2c+1. Writing one byte leaves the other byte unchanged. The other write addresses are: 10 pin select, 11 pin level, 12 action, 13 force, 14 flag clear, 15 interrupt enable. Compare registers reset to all ones.
- R2: A compare fires only in the first cycle in which the count equals the register. Pins and flags update on the clock edge that ends that cycle. While the equality persists, the channel does not fire again.
- R3: Channel c (1 to 4) acts on pin c-1. Its action field sits at bits [2c-1:2c-2] of the action register: 00 no effect, 01 invert, 10 drive low, 11 drive high.
- R4: When channel 0 fires, each pin whose select bit is 1 takes the matching level bit. The other pins keep their value. Pin 4 is driven only by channel 0.
- R5: If channel 0 and channel c fire on the same edge, the action of channel c decides pin c-1. An invert acts on the pin's value before that edge.
- R6: Writing a one to bit c of the force register acts on the pins at that same edge, exactly as a firing of channel c would. The flag of channel c is not set.
- R7: Every firing from a compare sets the channel's flag. The pin action is still taken when the flag was already set.
- R8: Writing a one to flag bit c at the clear address clears that flag. If channel c fires on the same edge, the flag stays set.
- R9: The interrupt output is high exactly when some flag and its enable bit are both 1.
- R10: After a high-byte write, the channel cannot fire in the next cycle. If the equality still holds in the cycle after that, the channel fires then. A low-byte write creates no such gap.
- R11: After reset, all pins, all flags and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntVal | input | 16 | Free-running count value |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| pinOut | output | 5 | Output pin levels |
| flagOut | output | 5 | Per-channel compare flags |
| irqOut | output | 1 | Interrupt request |

## Verification
Three kinds of event can land on the same edge, and each pair is tested:

- **Two compares on one pin.** Channel 0 and a slave channel compare against the same count value on the same pin, so both fire on one edge. The bench expects the slave's action to decide the pin and the master's level to decide the other selected pins.
- **Compare and flag clear.** A flag-clear write is issued in the same cycle as a first match on that channel. The flag must still read 1 afterwards, and a later clear with no match must drop it.
- **High-byte write and match.** A high-byte write makes the register equal to a count that is already present. The pin must not move on the next edge and must move one edge later.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int NCH = 5;

  localparam logic [3:0] ADDR_SEL = 4'd10;
  localparam logic [3:0] ADDR_LVL = 4'd11;
  localparam logic [3:0] ADDR_ACT = 4'd12;
  localparam logic [3:0] ADDR_FRC = 4'd13;
  localparam logic [3:0] ADDR_CLR = 4'd14;
  localparam logic [3:0] ADDR_IEN = 4'd15;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic [NCH-1:0] hit;  // first cycle of a compare match
    logic [NCH-1:0] frc;  // forced compare
    logic [NCH-1:0] clr;  // flag clear request
  } ocStrb_t;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic                 wrEn,
  input  logic [3:0]           wrAddr,
  input  logic [7:0]           wrData,
  output ocStrb_t              strb,
  output logic [NCH-1:0]       selQ,
  output logic [NCH-1:0]       lvlQ,
  output logic [2*NCH-3:0]     actQ,
  output logic [NCH-1:0]       ienQ,
  output logic [NCH*CNT_W-1:0] cmpFlat
);
  localparam int HI_W = CNT_W - 8;

  logic [NCH-1:0] hitV;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] cmpQ;
    logic inhQ, seenQ, eq, hiWr, loWr;

    assign hiWr = wrEn && (wrAddr == 4'(2*g));
    assign loWr = wrEn && (wrAddr == 4'(2*g+1));
    assign eq   = (cntVal == cmpQ);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmpQ  <= '1;
        inhQ  <= 1'b0;
        seenQ <= 1'b0;
      end else begin
        if (hiWr) cmpQ[CNT_W-1:8] <= wrData[HI_W-1:0];
        if (loWr) cmpQ[7:0] <= wrData;
        inhQ  <= hiWr;
        // an inhibited cycle does not count as having seen the match
        seenQ <= eq && !inhQ;
      end
    end

    assign hitV[g] = eq && !seenQ && !inhQ;
    assign cmpFlat[g*CNT_W +: CNT_W] = cmpQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selQ <= '0;
      lvlQ <= '0;
      actQ <= '0;
      ienQ <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_SEL: selQ <= wrData[NCH-1:0];
        ADDR_LVL: lvlQ <= wrData[NCH-1:0];
        ADDR_ACT: actQ <= wrData[2*NCH-3:0];
        ADDR_IEN: ienQ <= wrData[NCH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.hit = hitV;
    strb.frc = (wrEn && wrAddr == ADDR_FRC) ? wrData[NCH-1:0] : '0;
    strb.clr = (wrEn && wrAddr == ADDR_CLR) ? wrData[NCH-1:0] : '0;
  end
endmodule

// File: rtl/oc_path.sv
module oc_path
  import oc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ocStrb_t          strb,
  input  logic [NCH-1:0]   selQ,
  input  logic [NCH-1:0]   lvlQ,
  input  logic [2*NCH-3:0] actQ,
  input  logic [NCH-1:0]   ienQ,
  output logic [NCH-1:0]   pinQ,
  output logic [NCH-1:0]   flagQ,
  output logic             irq
);
  logic [NCH-1:0] fire, pinNxt;

  assign fire = strb.hit | strb.frc;

  always_comb begin
    pinNxt = pinQ;
    // master first, slaves override their own pin afterwards
    if (fire[0]) pinNxt = (pinQ & ~selQ) | (lvlQ & selQ);
    for (int c = 1; c < NCH; c++) begin
      if (fire[c]) begin
        case (actQ[2*(c-1) +: 2])
          2'b01:   pinNxt[c-1] = ~pinQ[c-1];
          2'b10:   pinNxt[c-1] = 1'b0;
          2'b11:   pinNxt[c-1] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinQ  <= '0;
      flagQ <= '0;
    end else begin
      pinQ  <= pinNxt;
      flagQ <= (flagQ & ~strb.clr) | strb.hit;
    end
  end

  assign irq = |(flagQ & ienQ);
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic [NCH-1:0]   pinOut,
  output logic [NCH-1:0]   flagOut,
  output logic             irqOut
);
  ocStrb_t                strb;
  logic [NCH-1:0]         selQ, lvlQ, ienQ;
  logic [2*NCH-3:0]       actQ;
  logic [NCH*CNT_W-1:0]   cmpFlat;

  oc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cntVal(cntVal),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .selQ(selQ), .lvlQ(lvlQ), .actQ(actQ),
    .ienQ(ienQ), .cmpFlat(cmpFlat)
  );

  oc_path u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .selQ(selQ), .lvlQ(lvlQ), .actQ(actQ), .ienQ(ienQ),
    .pinQ(pinOut), .flagQ(flagOut), .irq(irqOut)
  );
endmodule

// File: rtl/oc_unit_chk.sv
module oc_unit_chk
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     cntVal,
  input logic                 wrEn,
  input logic [3:0]           wrAddr,
  input logic [NCH-1:0]       pinOut,
  input logic [NCH-1:0]       flagOut,
  input ocStrb_t              strb,
  input logic [NCH*CNT_W-1:0] cmpFlat
);
  logic [NCH-1:0] matchV, hiMask;

  always_comb begin
    for (int g = 0; g < NCH; g++) begin
      matchV[g] = (cntVal == cmpFlat[g*CNT_W +: CNT_W]);
      hiMask[g] = wrEn && (wrAddr == 4'(2*g));
    end
  end

  // R7: a flag only rises after a cycle in which its channel matched
  a_r7_flag_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((flagOut & ~$past(flagOut)) & ~$past(matchV)) == '0);

  // R2: no channel fires on two consecutive cycles from a compare
  a_r2_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hit & $past(strb.hit)) == '0);

  // R8: a cleared flag without a simultaneous compare reads 0 next cycle
  a_r8_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb.clr) |=> ((flagOut & $past(strb.clr & ~strb.hit)) == '0));

  // R10: no compare in the cycle after a high-byte write
  a_r10_hi_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hiMask) & strb.hit) == '0);

  // R6: pins move only after a compare or a force
  a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|(strb.hit | strb.frc)) |-> $stable(pinOut));
endmodule

bind oc_unit oc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cntVal(cntVal), .wrEn(wrEn), .wrAddr(wrAddr),
  .pinOut(pinOut), .flagOut(flagOut), .strb(strb), .cmpFlat(cmpFlat)
);

// File: tb/oc_unit_tb.sv
`timescale 1ns/1ps
module oc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cntVal;
  logic        wrEn;
  logic [3:0]  wrAddr;
  logic [7:0]  wrData;
  logic [4:0]  pinOut, flagOut;
  logic        irqOut;

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [4:0] expPin;

  always #2 clk = ~clk;

  oc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cntVal(cntVal), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pinOut(pinOut), .flagOut(flagOut), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCmp(input int ch, input logic [15:0] v);
    wr(4'(2*ch), v[15:8]);
    wr(4'(2*ch+1), v[7:0]);
  endtask

  initial begin
    rst_n = 1'b0; cntVal = '0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 pins", 16'(pinOut), 16'h0);
    chk("R11 flags", 16'(flagOut), 16'h0);
    chk("R11 irq", 16'(irqOut), 16'h0);
    expPin = '0;

    // R3 / R2 / R7 / R8: each slave channel through each action
    for (int c = 1; c < 5; c++) begin
      for (int a = 1; a < 4; a++) begin
        wr(4'd12, 8'(a << (2*(c-1))));
        setCmp(c, 16'(100 + c));
        cntVal = 16'(100 + c);
        @(negedge clk);
        case (a)
          1: expPin[c-1] = ~expPin[c-1];
          2: expPin[c-1] = 1'b0;
          default: expPin[c-1] = 1'b1;
        endcase
        chk("R3 slave action", 16'(pinOut), 16'(expPin));
        chk("R7 flag set", 16'(flagOut), 16'(5'b1 << c));
        repeat (3) @(negedge clk);
        chk("R2 held match acts once", 16'(pinOut), 16'(expPin));
        cntVal = '0;
        @(negedge clk);
        wr(4'd14, 8'(1 << c));
        chk("R8 clear", 16'(flagOut), 16'h0);
      end
    end

    // R4 / R7: master select and level sweep, flag already set after the first
    wr(4'd12, 8'h00);
    setCmp(0, 16'd500);
    for (int m = 0; m < 32; m++) begin
      for (int k = 0; k < 2; k++) begin
        logic [4:0] d;
        d = k ? 5'b10101 : 5'b01010;
        wr(4'd10, 8'(m));
        wr(4'd11, 8'(d));
        cntVal = 16'd500;
        @(negedge clk);
        expPin = (expPin & ~5'(m)) | (d & 5'(m));
        chk("R4 master select/level", 16'(pinOut), 16'(expPin));
        cntVal = '0;
        @(negedge clk);
      end
    end
    chk("R7 flag stays with repeated action", 16'(flagOut), 16'h1);
    wr(4'd14, 8'h1F);

    // R5: master and two slaves fire on one edge
    wr(4'd12, 8'b0000_1011);
    wr(4'd10, 8'h1F);
    wr(4'd11, 8'b0000_0010);
    setCmp(0, 16'd700); setCmp(1, 16'd700); setCmp(2, 16'd700);
    cntVal = 16'd700;
    @(negedge clk);
    expPin = 5'b00001;
    chk("R5 slave wins", 16'(pinOut), 16'(expPin));
    chk("R7 three flags", 16'(flagOut), 16'h07);
    cntVal = '0;
    @(negedge clk);
    wr(4'd14, 8'h1F);

    // R6: forced compares move pins, leave flags
    wr(4'd12, 8'b0000_0001);
    wr(4'd13, 8'b0000_0010);
    expPin[0] = ~expPin[0];
    chk("R6 force slave", 16'(pinOut), 16'(expPin));
    chk("R6 force no flag", 16'(flagOut), 16'h0);
    wr(4'd10, 8'h10);
    wr(4'd11, 8'h10);
    wr(4'd13, 8'h01);
    expPin[4] = 1'b1;
    chk("R6 force master", 16'(pinOut), 16'(expPin));
    chk("R6 force master no flag", 16'(flagOut), 16'h0);

    // R8: clear on the same edge as a first match keeps the flag
    cntVal = 16'd700;
    wrEn = 1'b1; wrAddr = 4'd14; wrData = 8'h02;
    @(negedge clk);
    wrEn = 1'b0;
    expPin[0] = ~expPin[0];
    chk("R8 set wins over clear", 16'(flagOut), 16'h07);
    chk("R5 pins after joint fire", 16'(pinOut), 16'(expPin));
    cntVal = '0;
    @(negedge clk);
    wr(4'd14, 8'h02);
    chk("R8 later clear", 16'(flagOut), 16'h05);

    // R9: interrupt enables
    wr(4'd15, 8'h02);
    chk("R9 disabled flag no irq", 16'(irqOut), 16'h0);
    wr(4'd15, 8'h04);
    chk("R9 enabled flag irq", 16'(irqOut), 16'h1);
    wr(4'd14, 8'h1F);
    chk("R9 irq drops with flag", 16'(irqOut), 16'h0);
    wr(4'd15, 8'h00);

    // R10: high-byte write completes a match, fire delayed one cycle
    wr(4'd12, 8'b0001_0000);
    wr(4'd7, 8'h20);
    cntVal = 16'h0320;
    wr(4'd6, 8'h03);
    chk("R10 inhibited cycle 1", 16'(pinOut), 16'(expPin));
    @(negedge clk);
    chk("R10 inhibited cycle 2", 16'(pinOut), 16'(expPin));
    @(negedge clk);
    expPin[2] = ~expPin[2];
    chk("R10 fires after gap", 16'(pinOut), 16'(expPin));
    cntVal = '0;
    @(negedge clk);

    // R1 / R10: low-byte write keeps high byte, fires without gap
    cntVal = 16'h0345;
    wr(4'd7, 8'h45);
    chk("R1 low write edge", 16'(pinOut), 16'(expPin));
    @(negedge clk);
    expPin[2] = ~expPin[2];
    chk("R1 low byte alone, no gap", 16'(pinOut), 16'(expPin));
    cntVal = '0;
    @(negedge clk);

    // R1: high-byte write keeps low byte
    wr(4'd6, 8'h12);
    cntVal = 16'h1245;
    repeat (2) @(negedge clk);
    expPin[2] = ~expPin[2];
    chk("R1 high byte alone", 16'(pinOut), 16'(expPin));
    cntVal = '0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule